// File: doc/BRIEF.md
# Host Register Port with Event Queue

This block is the slave side of an 8-bit parallel host bus for a multi-channel voice processing device. The host selects the port with an active-low chip select and an active-low data strobe, gives an 11-bit address and a read/write direction, and waits for an active-low acknowledge. The address space holds thirty-two equal per-channel register windows, a small bank of shared control bytes, a read-only event queue location and a test byte. Each register holds its own power-on value, and one reserved bit always reads back as zero.

Inside the device, processing logic reports events as one-cycle pulses that carry a channel number. The block queues these pulses in arrival order. The interrupt output stays low while an event is waiting, so the host drains the queue by reading one address until that address returns zero. A test bit forces the interrupt line low with no event pending, which lets the interrupt wiring be exercised.

All inputs are taken as synchronous to `clk`. The registers have no effect on signal processing here; they are storage only.

Top module: `hostRegPort`

## Requirements
- R1: After reset, every channel window of 32 bytes reads 00h except these offsets within the window: 15h reads 48h, 16h reads 60h, 17h reads 0Bh, and 0Bh reads 74h in even channels and 0Ch in odd channels.
- R2: Channel N owns addresses N*20h to N*20h+1Fh, for N from 0 to 31. A write to one byte changes only that byte, and a read returns the last value written.
- R3: Bit 0 of offset 00h in an odd channel's window always reads 0, whatever is written. In an even channel the same bit stores normally.
- R4: Addresses 0400h to 040Fh are sixteen independent read/write bytes that reset to 00h.
- R5: ackN goes low on the second rising edge after the first rising edge that samples csN and dsN both low, which is three negative clock edges after the inputs are driven. It returns high after the first rising edge that samples csN high.
- R6: An event pulse (evValid high for one edge) appends evChan to the queue. Each read of 0410h removes the oldest entry and returns it as bit 7 = 1, bits 6:5 = 0 and bits 4:0 = channel. When the queue is empty, the read returns 00h.
- R7: The queue holds 16 entries. An event that arrives while 16 entries are held, with no removal on the same edge, is discarded.
- R8: irqN is low exactly while the queue holds at least one entry or the test bit is 1.
- R9: Address 0411h holds the test bit in bit 0, and its other bits read 0. Writes to 0410h and to addresses 0412h to 07FFh are ignored, and reads of 0412h to 07FFh return 00h.
- R10: When an event arrives on the same edge as a queue read, both take effect. The read returns the older head, and the new channel joins the tail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| csN | input | 1 | Active-low chip select |
| dsN | input | 1 | Active-low data strobe |
| rnw | input | 1 | 1 = read, 0 = write |
| addr | input | 11 | Register address |
| dataIn | input | 8 | Write data |
| dataOut | output | 8 | Read data, valid while ackN is low on a read, otherwise 00h |
| ackN | output | 1 | Active-low transfer acknowledge |
| irqN | output | 1 | Active-low interrupt |
| evValid | input | 1 | Event pulse |
| evChan | input | 5 | Channel number carried by the event |

## Verification
The queue read and an incoming event can land on the same clock edge: the read's removal and the event's append then act on the queue in one cycle. The bench provokes this by starting a read of 0410h and, in a parallel thread, pulsing evValid on exactly the edge where the acknowledge falls. It then judges the result from the value returned on that read and from the order and count of entries that the following reads drain. The full-queue case is also driven with an extra event, to show that the queue keeps sixteen entries and drops the newcomer.

// File: rtl/hostRegPkg.sv
package hostRegPkg;
  localparam int ADDR_W = 11;
  localparam int DATA_W = 8;

  // Strobes from the bus sequencer to the register datapath
  typedef struct packed {
    logic              wr;
    logic              rd;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wdata;
  } regCmd_t;
endpackage

// File: rtl/hostRegCtrl.sv
module hostRegCtrl
  import hostRegPkg::*;
#(
  parameter int ACK_WAIT = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              dsN,
  input  logic              rnw,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  output regCmd_t           cmd,
  output logic              ackN,
  output logic              driveRd
);
  localparam int WAIT_W = (ACK_WAIT > 1) ? $clog2(ACK_WAIT) : 1;

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_ACK} busState_t;

  busState_t         state;
  logic [WAIT_W-1:0] waitCnt;
  logic              isRead;
  logic              fire;

  assign fire = (state == S_WAIT) && !csN && (waitCnt == WAIT_W'(ACK_WAIT - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      waitCnt <= '0;
      isRead  <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          if (!csN && !dsN) begin
            state   <= S_WAIT;
            waitCnt <= '0;
          end
        end
        S_WAIT: begin
          if (csN) begin
            state <= S_IDLE;
          end else if (fire) begin
            state  <= S_ACK;
            isRead <= rnw;
          end else begin
            waitCnt <= waitCnt + WAIT_W'(1);
          end
        end
        S_ACK: begin
          if (csN) state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    cmd.wr    = fire && !rnw;
    cmd.rd    = fire && rnw;
    cmd.addr  = addr;
    cmd.wdata = dataIn;
  end

  assign ackN    = (state != S_ACK);
  assign driveRd = (state == S_ACK) && isRead;
endmodule

// File: rtl/hostEvtFifo.sv
module hostEvtFifo #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 5
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       push,
  input  logic [WIDTH-1:0]           pushData,
  input  logic                       pop,
  output logic [WIDTH-1:0]           headData,
  output logic                       empty,
  output logic [$clog2(DEPTH+1)-1:0] level
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] store [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;
  logic             doPop, doPush;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign doPop  = pop && (count != '0);
  assign doPush = push && ((count != CNT_W'(DEPTH)) || doPop);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      count <= count + CNT_W'(doPush) - CNT_W'(doPop);
    end
  end

  always_ff @(posedge clk) begin
    if (doPush) store[wrPtr] <= pushData;
  end

  assign headData = store[rdPtr];
  assign empty    = (count == '0);
  assign level    = count;
endmodule

// File: rtl/hostRegBank.sv
module hostRegBank
  import hostRegPkg::*;
#(
  parameter int CHAN_COUNT = 32,
  parameter int WIN_BYTES  = 32,
  parameter int MAIN_COUNT = 16
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  regCmd_t                       cmd,
  input  logic                          fifoEmpty,
  input  logic [$clog2(CHAN_COUNT)-1:0] headChan,
  output logic                          popReq,
  output logic [DATA_W-1:0]             rdData,
  output logic                          irqN
);
  localparam int CH_W      = $clog2(CHAN_COUNT);
  localparam int CH_BYTES  = CHAN_COUNT * WIN_BYTES;
  localparam int CH_AW     = $clog2(CH_BYTES);
  localparam int OFF_W     = $clog2(WIN_BYTES);
  localparam int MAIN_AW   = $clog2(MAIN_COUNT);
  localparam int MAIN_BASE = CH_BYTES;
  localparam int FIFO_ADDR = MAIN_BASE + MAIN_COUNT;
  localparam int TEST_ADDR = FIFO_ADDR + 1;
  localparam int PAD_W     = DATA_W - 1 - CH_W;

  logic [DATA_W-1:0] chanMem [CH_BYTES];
  logic [DATA_W-1:0] mainMem [MAIN_COUNT];
  logic              testBit;
  logic [31:0]       addrVal;
  logic              chanHit, mainHit, fifoHit, testHit;
  logic [DATA_W-1:0] wrByte;

  // Power-on content of a channel byte, by position in its window pair
  function automatic logic [DATA_W-1:0] resetVal(input int idx);
    int winOff;
    int pairOff;
    winOff  = idx % WIN_BYTES;
    pairOff = idx % (2 * WIN_BYTES);
    if (pairOff == 'h0B)                  return 8'h74;
    else if (pairOff == WIN_BYTES + 'h0B) return 8'h0C;
    else if (winOff == 'h15)              return 8'h48;
    else if (winOff == 'h16)              return 8'h60;
    else if (winOff == 'h17)              return 8'h0B;
    else                                  return 8'h00;
  endfunction

  assign addrVal = 32'(cmd.addr);
  assign chanHit = addrVal < 32'(CH_BYTES);
  assign mainHit = (addrVal >= 32'(MAIN_BASE)) && (addrVal < 32'(FIFO_ADDR));
  assign fifoHit = addrVal == 32'(FIFO_ADDR);
  assign testHit = addrVal == 32'(TEST_ADDR);

  // Odd-channel first byte: bit 0 is held at zero
  always_comb begin
    wrByte = cmd.wdata;
    if (cmd.addr[OFF_W] && (cmd.addr[OFF_W-1:0] == '0)) wrByte[0] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < CH_BYTES; i++) chanMem[i] <= resetVal(i);
    end else if (cmd.wr && chanHit) begin
      chanMem[cmd.addr[CH_AW-1:0]] <= wrByte;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < MAIN_COUNT; i++) mainMem[i] <= '0;
      testBit <= 1'b0;
    end else if (cmd.wr) begin
      if (mainHit) mainMem[cmd.addr[MAIN_AW-1:0]] <= cmd.wdata;
      if (testHit) testBit <= cmd.wdata[0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (cmd.rd) begin
      if (chanHit)      rdData <= chanMem[cmd.addr[CH_AW-1:0]];
      else if (mainHit) rdData <= mainMem[cmd.addr[MAIN_AW-1:0]];
      else if (fifoHit) rdData <= fifoEmpty ? '0 : {1'b1, {PAD_W{1'b0}}, headChan};
      else if (testHit) rdData <= {{(DATA_W-1){1'b0}}, testBit};
      else              rdData <= '0;
    end
  end

  assign popReq = cmd.rd && fifoHit;
  assign irqN   = !(!fifoEmpty || testBit);
endmodule

// File: rtl/hostRegPort.sv
module hostRegPort
  import hostRegPkg::*;
#(
  parameter int CHAN_COUNT = 32,
  parameter int WIN_BYTES  = 32,
  parameter int MAIN_COUNT = 16,
  parameter int FIFO_DEPTH = 16,
  parameter int ACK_WAIT   = 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          csN,
  input  logic                          dsN,
  input  logic                          rnw,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [DATA_W-1:0]             dataIn,
  output logic [DATA_W-1:0]             dataOut,
  output logic                          ackN,
  output logic                          irqN,
  input  logic                          evValid,
  input  logic [$clog2(CHAN_COUNT)-1:0] evChan
);
  localparam int CH_W  = $clog2(CHAN_COUNT);
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

  regCmd_t           cmd;
  logic              driveRd;
  logic              popReq;
  logic              fifoEmpty;
  logic [CH_W-1:0]   headChan;
  logic [CNT_W-1:0]  fifoLevel;
  logic [DATA_W-1:0] rdData;

  hostRegCtrl #(.ACK_WAIT(ACK_WAIT)) uCtrl (
    .clk(clk), .rstN(rstN), .csN(csN), .dsN(dsN), .rnw(rnw),
    .addr(addr), .dataIn(dataIn), .cmd(cmd), .ackN(ackN), .driveRd(driveRd)
  );

  hostRegBank #(
    .CHAN_COUNT(CHAN_COUNT), .WIN_BYTES(WIN_BYTES), .MAIN_COUNT(MAIN_COUNT)
  ) uBank (
    .clk(clk), .rstN(rstN), .cmd(cmd), .fifoEmpty(fifoEmpty),
    .headChan(headChan), .popReq(popReq), .rdData(rdData), .irqN(irqN)
  );

  hostEvtFifo #(.DEPTH(FIFO_DEPTH), .WIDTH(CH_W)) uFifo (
    .clk(clk), .rstN(rstN), .push(evValid), .pushData(evChan),
    .pop(popReq), .headData(headChan), .empty(fifoEmpty), .level(fifoLevel)
  );

  assign dataOut = driveRd ? rdData : '0;
endmodule

// File: rtl/hostRegPortChk.sv
module hostRegPortChk #(
  parameter int FIFO_DEPTH = 16
) (
  input logic                            clk,
  input logic                            rstN,
  input logic                            csN,
  input logic                            dsN,
  input logic                            ackN,
  input logic                            irqN,
  input logic                            evValid,
  input logic                            popReq,
  input logic [$clog2(FIFO_DEPTH+1)-1:0] fifoLevel
);
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

  AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    csN |=> ackN); // R5

  AST_ACK_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ackN) |-> (!$past(csN, 1) && !$past(csN, 2))); // R5

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    fifoLevel <= CNT_W'(FIFO_DEPTH)); // R7

  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (evValid && !popReq && fifoLevel == CNT_W'(FIFO_DEPTH)) |=> fifoLevel == CNT_W'(FIFO_DEPTH)); // R7

  AST_IRQ_PENDING: assert property (@(posedge clk) disable iff (!rstN)
    (fifoLevel != '0) |-> !irqN); // R8

  AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (!rstN)
    (evValid && !popReq && fifoLevel < CNT_W'(FIFO_DEPTH)) |=> fifoLevel == $past(fifoLevel) + CNT_W'(1)); // R6

  AST_SAME_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    (evValid && popReq && fifoLevel != '0) |=> $stable(fifoLevel)); // R10
endmodule

bind hostRegPort hostRegPortChk #(.FIFO_DEPTH(FIFO_DEPTH)) uChk (
  .clk(clk), .rstN(rstN), .csN(csN), .dsN(dsN), .ackN(ackN), .irqN(irqN),
  .evValid(evValid), .popReq(popReq), .fifoLevel(fifoLevel)
);

// File: tb/tb_hostRegPort.sv
module tb_hostRegPort;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       csN = 1'b1, dsN = 1'b1, rnw = 1'b1;
  logic [10:0] addrIn = '0;
  logic [7:0] dataIn = '0;
  logic [7:0] dataOut;
  logic       ackN, irqN;
  logic       evValid = 1'b0;
  logic [4:0] evChan = '0;

  int checks = 0;
  int errors = 0;
  int lastLat = 0;
  logic lastRelease = 1'b1;

  typedef struct {
    logic [7:0] val;
    string      tag;
  } expItem_t;
  expItem_t expQ[$];

  hostRegPort dut (
    .clk(clk), .rstN(rstN), .csN(csN), .dsN(dsN), .rnw(rnw), .addr(addrIn),
    .dataIn(dataIn), .dataOut(dataOut), .ackN(ackN), .irqN(irqN),
    .evValid(evValid), .evChan(evChan)
  );

  always #2.5 clk = ~clk;

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic doAccess(input logic rd, input logic [10:0] a, input logic [7:0] d);
    int lat;
    @(negedge clk);
    rnw = rd; addrIn = a; dataIn = d; csN = 1'b0; dsN = 1'b0;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (ackN && lat < 40);
    lastLat = lat;
    csN = 1'b1; dsN = 1'b1;
    @(negedge clk);
    lastRelease = ackN;
  endtask

  task automatic wr(input logic [10:0] a, input logic [7:0] d);
    doAccess(1'b0, a, d);
  endtask

  task automatic rdExp(input logic [10:0] a, input logic [7:0] e, input string tag);
    expItem_t it;
    it.val = e; it.tag = tag;
    expQ.push_back(it);
    doAccess(1'b1, a, 8'h00);
  endtask

  task automatic pulseEvent(input logic [4:0] ch);
    @(negedge clk);
    evValid = 1'b1; evChan = ch;
    @(negedge clk);
    evValid = 1'b0;
  endtask

  // Monitor: compare read data on each falling edge of the acknowledge
  initial begin
    logic ackPrev;
    ackPrev = 1'b1;
    forever begin
      @(negedge clk);
      if (ackPrev && !ackN && rnw) begin
        if (expQ.size() == 0) begin
          check(1'b0, "unexpected read", dataOut, 0);
        end else begin
          expItem_t it;
          it = expQ.pop_front();
          check(dataOut == it.val, it.tag, dataOut, it.val);
        end
      end
      ackPrev = ackN;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(ackN == 1'b1, "R5 ack idle after reset", ackN, 1);
    check(irqN == 1'b1, "R8 irq idle after reset", irqN, 1);

    // R1 reset contents
    rdExp(11'h000, 8'h00, "R1 ch0 off00");
    check(lastLat == 3, "R5 ack latency", lastLat, 3);
    check(lastRelease == 1'b1, "R5 ack release", lastRelease, 1);
    rdExp(11'h00B, 8'h74, "R1 ch0 off0B");
    rdExp(11'h02B, 8'h0C, "R1 ch1 off0B");
    rdExp(11'h014, 8'h00, "R1 ch0 off14");
    rdExp(11'h015, 8'h48, "R1 ch0 off15");
    rdExp(11'h016, 8'h60, "R1 ch0 off16");
    rdExp(11'h017, 8'h0B, "R1 ch0 off17");
    rdExp(11'h3CB, 8'h74, "R1 ch30 off0B");
    rdExp(11'h3EB, 8'h0C, "R1 ch31 off0B");
    rdExp(11'h3F5, 8'h48, "R1 ch31 off15");

    // R2 window decode
    wr(11'h3FF, 8'hA5);
    check(lastLat == 3, "R5 write ack latency", lastLat, 3);
    wr(11'h3DF, 8'h5A);
    rdExp(11'h3FF, 8'hA5, "R2 ch31 off1F");
    rdExp(11'h3DF, 8'h5A, "R2 ch30 off1F");
    rdExp(11'h01F, 8'h00, "R2 ch0 off1F untouched");
    wr(11'h1EB, 8'h33);
    rdExp(11'h1EB, 8'h33, "R2 ch15 off0B");
    rdExp(11'h20B, 8'h74, "R2 ch16 off0B untouched");

    // R3 reserved bit
    wr(11'h020, 8'hFF);
    rdExp(11'h020, 8'hFE, "R3 odd ch bit0");
    wr(11'h000, 8'hFF);
    rdExp(11'h000, 8'hFF, "R3 even ch bit0");
    wr(11'h3E0, 8'h03);
    rdExp(11'h3E0, 8'h02, "R3 ch31 bit0");

    // R4 shared control bytes
    rdExp(11'h400, 8'h00, "R4 reset");
    wr(11'h40F, 8'hC3);
    wr(11'h400, 8'h11);
    rdExp(11'h40F, 8'hC3, "R4 top byte");
    rdExp(11'h400, 8'h11, "R4 bottom byte");

    // R9 / R8 test register and unmapped space
    wr(11'h411, 8'hFF);
    check(irqN == 1'b0, "R8 test bit forces irq", irqN, 0);
    rdExp(11'h411, 8'h01, "R9 test reg bits");
    wr(11'h411, 8'h00);
    check(irqN == 1'b1, "R8 test bit cleared", irqN, 1);
    wr(11'h410, 8'h77);
    rdExp(11'h410, 8'h00, "R9 queue write ignored");
    check(irqN == 1'b1, "R9 queue write no irq", irqN, 1);
    wr(11'h7FF, 8'hFF);
    rdExp(11'h7FF, 8'h00, "R9 unmapped 7FF");
    rdExp(11'h412, 8'h00, "R9 unmapped 412");
    rdExp(11'h40F, 8'hC3, "R9 unmapped write no alias");

    // R6 ordering and pop
    pulseEvent(5'd3);
    @(negedge clk);
    check(irqN == 1'b0, "R8 irq on event", irqN, 0);
    pulseEvent(5'd9);
    rdExp(11'h410, 8'h83, "R6 first entry");
    check(irqN == 1'b0, "R8 irq still pending", irqN, 0);
    rdExp(11'h410, 8'h89, "R6 second entry");
    check(irqN == 1'b1, "R8 irq after drain", irqN, 1);
    rdExp(11'h410, 8'h00, "R6 empty read");

    // R7 capacity and drop
    for (int i = 0; i < 17; i++) pulseEvent(5'(i));
    for (int i = 0; i < 16; i++) rdExp(11'h410, 8'h80 | 8'(i), "R7 full drain");
    rdExp(11'h410, 8'h00, "R7 seventeenth dropped");
    check(irqN == 1'b1, "R8 irq after full drain", irqN, 1);

    // R10 read and event on the same edge
    pulseEvent(5'd3);
    pulseEvent(5'd9);
    fork
      rdExp(11'h410, 8'h83, "R10 head on shared edge");
      begin
        repeat (3) @(negedge clk);
        evValid = 1'b1; evChan = 5'd21;
        @(negedge clk);
        evValid = 1'b0;
      end
    join
    rdExp(11'h410, 8'h89, "R10 second entry");
    rdExp(11'h410, 8'h95, "R10 appended entry");
    rdExp(11'h410, 8'h00, "R10 queue empty");

    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "scoreboard drained", expQ.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule